// File: doc/BRIEF.md
# Page Buffer Manager with LRU Replacement

The block holds a small set of page buffers in front of a large non-volatile main memory and serves a single simplified core request port from them. A page is 8 words. The address of a request is split into a page tag (upper bits) and a word offset (lower `log2(WORDS)` bits). When the tag matches a valid resident buffer, the access completes in the same cycle. When it does not match, the requester is stalled. The least-recently-used buffer is chosen as the victim. If that buffer is dirty, its whole page is written out first. The new page is then read in over a page-wide port, one full page per cycle.

The same RTL covers both sides of the memory system, selected by a parameter. The data side (default: 16 buffers of 16-bit words) accepts writes and tracks dirty pages. The program side (8 buffers of 24-bit words, `WB_EN = 0`) is read-only, ignores the write strobe and never drives a write to main memory. A sleep controller pulses `flush_req` before power-down. Every dirty data buffer is then written back, one per cycle, and `flush_done` marks the end.

The controller has four states:
- `ST_IDLE` serves hits.
- `ST_WBACK` writes out a dirty victim.
- `ST_FILL` loads the missing page.
- `ST_FLUSH` drains the dirty buffers.

Its transitions are:
- `ST_IDLE` to `ST_FLUSH` on `flush_req`. This takes priority over a request in the same cycle.
- `ST_IDLE` to `ST_WBACK` on a miss whose victim is valid and dirty.
- `ST_IDLE` to `ST_FILL` on any other miss.
- `ST_WBACK` to `ST_FILL`, always.
- `ST_FILL` to `ST_IDLE`, always.
- `ST_FLUSH` stays in `ST_FLUSH` while any buffer is dirty.
- `ST_FLUSH` to `ST_IDLE` in the cycle that raises `flush_done`.

Top module: `pbuf_mgr`

## Requirements
- R1: In `ST_IDLE` with `req_valid` high, no `flush_req`, and a matching valid buffer, `stall` is low and `rsp_rdata` carries the addressed word in the same cycle. Word k of a page occupies bits `[k*WW +: WW]`.
- R2: On the data side, a write hit stores `req_wdata` into the addressed word at the clock edge and marks the buffer dirty. On the program side, `req_we` has no effect, and a later read returns the original word.
- R3: A miss raises `stall` combinationally. The fill cycle drives `nvm_rd_en` with `nvm_rd_page` equal to the requested tag and loads the whole page from `nvm_rd_data`. `nvm_rd_en` and `nvm_wr_en` are never high together.
- R4: After reset, all buffers are invalid and buffer i has age i, so buffer NBUF-1 is the oldest. A hit or a fill makes that buffer the most recent. The victim of a miss is always the oldest buffer.
- R5: A miss whose victim is valid and dirty spends exactly one cycle with `nvm_wr_en` high, `nvm_wr_page` set to the victim's tag and `nvm_wr_data` set to its whole page. The fill cycle follows immediately.
- R6: `stall` falls in the cycle after the fill cycle, provided the request is held.
- R7: After `flush_req`, each dirty buffer is written back, one per cycle, lowest index first, and its dirty flag is cleared. Clean buffers are not written. Then `flush_done` is high for exactly one cycle, and `stall` stays high throughout.
- R8: On the program side, `nvm_wr_en` is never raised, and a flush ends with `flush_done` in the cycle after `flush_req`.
- R9: While and right after reset with no request, `stall`, `nvm_rd_en`, `nvm_wr_en` and `flush_done` are low.
- R10: When `flush_req` and a missing request arrive in the same `ST_IDLE` cycle, the flush is done first. The miss is serviced afterwards, with ages and buffer contents as the flush left them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_we | input | 1 | Request is a write |
| req_addr | input | TAG_W+log2(WORDS) | Page tag and word offset |
| req_wdata | input | WW | Write word |
| rsp_rdata | output | WW | Read word, valid when request is high and stall is low |
| stall | output | 1 | Core must hold its request |
| flush_req | input | 1 | Pulse: write back all dirty pages |
| flush_done | output | 1 | Pulse: flush finished |
| nvm_rd_en | output | 1 | Page read from main memory this cycle |
| nvm_rd_page | output | TAG_W | Page being read |
| nvm_rd_data | input | WORDS*WW | Page contents, combinational from main memory |
| nvm_wr_en | output | 1 | Page write to main memory this cycle |
| nvm_wr_page | output | TAG_W | Page being written |
| nvm_wr_data | output | WORDS*WW | Page contents written |

## Verification
The assertions assume two things about the inputs. First, a stalled requester keeps `req_valid`, `req_we`, `req_addr` and `req_wdata` steady until `stall` falls. Second, the main memory answers a page read combinationally within the fill cycle. The stimulus meets both: each access is held until the reference model predicts that `stall` will be low, and the bench supplies `nvm_rd_data` from its own page store as soon as `nvm_rd_page` changes. Flush requests are one-cycle pulses issued from `ST_IDLE`, one of them alongside a missing request.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2,
        ST_FLUSH = 2'd3
    } pbuf_state_e;
endpackage

// File: rtl/pbuf_lru.sv
module pbuf_lru #(
    parameter int NBUF = 16,
    localparam int IW = $clog2(NBUF)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch_en,
    input  logic [IW-1:0] touch_idx,
    output logic [IW-1:0] victim
);
    // age per buffer: 0 = most recent, NBUF-1 = oldest
    logic [IW-1:0]   age_q [NBUF];
    logic [NBUF-1:0] oldest_vec;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBUF; i++) age_q[i] <= IW'(i);
        end else if (touch_en) begin
            for (int i = 0; i < NBUF; i++) begin
                if (IW'(i) == touch_idx)
                    age_q[i] <= '0;
                else if (age_q[i] < age_q[touch_idx])
                    age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    always_comb begin
        victim = '0;
        for (int i = 0; i < NBUF; i++) begin
            oldest_vec[i] = (age_q[i] == IW'(NBUF - 1));
            if (oldest_vec[i]) victim = IW'(i);
        end
    end

    AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest_vec) == 1); // R4
    AST_TOUCH_MRU: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> age_q[$past(touch_idx)] == '0); // R4
endmodule

// File: rtl/pbuf_store.sv
module pbuf_store #(
    parameter int NBUF  = 16,
    parameter int WORDS = 8,
    parameter int WW    = 16,
    parameter int TAG_W = 12,
    parameter bit WB_EN = 1'b1,
    localparam int IW = $clog2(NBUF),
    localparam int OW = $clog2(WORDS),
    localparam int PB = WORDS * WW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] look_tag,
    input  logic [OW-1:0]    look_off,
    output logic             hit,
    output logic [IW-1:0]    hit_idx,
    output logic [WW-1:0]    hit_word,
    input  logic             word_we,
    input  logic [WW-1:0]    word_data,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [PB-1:0]    fill_data,
    input  logic             clean_en,
    input  logic [IW-1:0]    sel_idx,
    output logic [TAG_W-1:0] sel_tag,
    output logic [PB-1:0]    sel_page,
    output logic [NBUF-1:0]  valid_vec,
    output logic [NBUF-1:0]  dirty_vec
);
    logic [PB-1:0]    page_q [NBUF];
    logic [TAG_W-1:0] tag_q  [NBUF];
    logic [NBUF-1:0]  match_vec;

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < NBUF; i++) begin
            match_vec[i] = valid_vec[i] && (tag_q[i] == look_tag);
            if (match_vec[i]) begin
                hit     = 1'b1;
                hit_idx = IW'(i);
            end
        end
    end

    assign hit_word = page_q[hit_idx][look_off*WW +: WW];
    assign sel_tag  = tag_q[sel_idx];
    assign sel_page = page_q[sel_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_vec <= '0;
            for (int i = 0; i < NBUF; i++) tag_q[i] <= '0;
        end else if (fill_en) begin
            valid_vec[sel_idx] <= 1'b1;
            tag_q[sel_idx]     <= fill_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en)
            page_q[sel_idx] <= fill_data;
        else if (word_we && WB_EN)
            page_q[hit_idx][look_off*WW +: WW] <= word_data;
    end

    generate
        if (WB_EN) begin : g_dirty
            always_ff @(posedge clk) begin
                if (!rst_n)
                    dirty_vec <= '0;
                else if (fill_en || clean_en)
                    dirty_vec[sel_idx] <= 1'b0;
                else if (word_we)
                    dirty_vec[hit_idx] <= 1'b1;
            end
        end else begin : g_clean
            assign dirty_vec = '0;
        end
    endgenerate

    AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec)); // R1
    AST_WRITE_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (word_we && WB_EN) |=> dirty_vec[$past(hit_idx)]); // R2
endmodule

// File: rtl/pbuf_ctrl.sv
module pbuf_ctrl
    import pbuf_pkg::*;
#(
    parameter int NBUF  = 16,
    parameter int TAG_W = 12,
    parameter bit WB_EN = 1'b1,
    localparam int IW = $clog2(NBUF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_we,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             req_hit,
    input  logic [IW-1:0]    hit_idx,
    input  logic             flush_req,
    input  logic [IW-1:0]    lru_victim,
    input  logic [NBUF-1:0]  valid_vec,
    input  logic [NBUF-1:0]  dirty_vec,
    output logic             stall,
    output logic             nvm_rd_en,
    output logic             nvm_wr_en,
    output logic             flush_done,
    output logic             touch_en,
    output logic [IW-1:0]    touch_idx,
    output logic             word_we,
    output logic             fill_en,
    output logic             clean_en,
    output logic [IW-1:0]    sel_idx,
    output logic [TAG_W-1:0] fill_tag
);
    pbuf_state_e      state_q, state_d;
    logic [IW-1:0]    vic_q;
    logic [TAG_W-1:0] tag_q;
    logic             fl_any;
    logic [IW-1:0]    fl_idx;
    logic             miss;

    // lowest-index dirty buffer is drained first
    always_comb begin
        fl_any = |dirty_vec;
        fl_idx = '0;
        for (int i = NBUF - 1; i >= 0; i--)
            if (dirty_vec[i]) fl_idx = IW'(i);
    end

    assign miss     = req_valid && !req_hit && !flush_req;
    assign fill_tag = tag_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (flush_req)
                    state_d = ST_FLUSH;
                else if (miss)
                    state_d = (valid_vec[lru_victim] && dirty_vec[lru_victim])
                              ? ST_WBACK : ST_FILL;
            end
            ST_WBACK: state_d = ST_FILL;
            ST_FILL:  state_d = ST_IDLE;
            ST_FLUSH: if (!fl_any) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vic_q   <= '0;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && miss) begin
                vic_q <= lru_victim;
                tag_q <= req_tag;
            end
        end
    end

    always_comb begin
        stall      = 1'b1;
        nvm_rd_en  = 1'b0;
        nvm_wr_en  = 1'b0;
        flush_done = 1'b0;
        touch_en   = 1'b0;
        touch_idx  = vic_q;
        word_we    = 1'b0;
        fill_en    = 1'b0;
        clean_en   = 1'b0;
        sel_idx    = vic_q;
        unique case (state_q)
            ST_IDLE: begin
                stall     = req_valid && (flush_req || !req_hit);
                touch_en  = req_valid && req_hit && !flush_req;
                touch_idx = hit_idx;
                word_we   = touch_en && req_we && WB_EN;
            end
            ST_WBACK: begin
                nvm_wr_en = 1'b1;
                clean_en  = 1'b1;
            end
            ST_FILL: begin
                nvm_rd_en = 1'b1;
                fill_en   = 1'b1;
                touch_en  = 1'b1;
            end
            ST_FLUSH: begin
                sel_idx    = fl_idx;
                nvm_wr_en  = fl_any;
                clean_en   = fl_any;
                flush_done = !fl_any;
            end
        endcase
    end

    AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WBACK) |=> nvm_rd_en); // R5
    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(nvm_rd_en && nvm_wr_en)); // R3
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH && nvm_wr_en) |=> !dirty_vec[$past(sel_idx)]); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |=> !flush_done); // R7

    generate
        if (!WB_EN) begin : g_ro_chk
            AST_PROG_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
                !nvm_wr_en); // R8
        end
    endgenerate
endmodule

// File: rtl/pbuf_mgr.sv
module pbuf_mgr #(
    parameter int NBUF  = 16,
    parameter int WORDS = 8,
    parameter int WW    = 16,
    parameter int TAG_W = 12,
    parameter bit WB_EN = 1'b1,
    localparam int IW = $clog2(NBUF),
    localparam int OW = $clog2(WORDS),
    localparam int AW = TAG_W + OW,
    localparam int PB = WORDS * WW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_we,
    input  logic [AW-1:0]    req_addr,
    input  logic [WW-1:0]    req_wdata,
    output logic [WW-1:0]    rsp_rdata,
    output logic             stall,
    input  logic             flush_req,
    output logic             flush_done,
    output logic             nvm_rd_en,
    output logic [TAG_W-1:0] nvm_rd_page,
    input  logic [PB-1:0]    nvm_rd_data,
    output logic             nvm_wr_en,
    output logic [TAG_W-1:0] nvm_wr_page,
    output logic [PB-1:0]    nvm_wr_data
);
    logic [TAG_W-1:0] req_tag, fill_tag;
    logic [OW-1:0]    req_off;
    logic             hit, touch_en, word_we, fill_en, clean_en;
    logic [IW-1:0]    hit_idx, touch_idx, sel_idx, lru_victim;
    logic [NBUF-1:0]  valid_vec, dirty_vec;

    assign req_tag     = req_addr[AW-1:OW];
    assign req_off     = req_addr[OW-1:0];
    assign nvm_rd_page = fill_tag;

    pbuf_store #(.NBUF(NBUF), .WORDS(WORDS), .WW(WW), .TAG_W(TAG_W), .WB_EN(WB_EN)) store_i (
        .clk(clk), .rst_n(rst_n),
        .look_tag(req_tag), .look_off(req_off),
        .hit(hit), .hit_idx(hit_idx), .hit_word(rsp_rdata),
        .word_we(word_we), .word_data(req_wdata),
        .fill_en(fill_en), .fill_tag(fill_tag), .fill_data(nvm_rd_data),
        .clean_en(clean_en), .sel_idx(sel_idx),
        .sel_tag(nvm_wr_page), .sel_page(nvm_wr_data),
        .valid_vec(valid_vec), .dirty_vec(dirty_vec)
    );

    pbuf_lru #(.NBUF(NBUF)) lru_i (
        .clk(clk), .rst_n(rst_n),
        .touch_en(touch_en), .touch_idx(touch_idx), .victim(lru_victim)
    );

    pbuf_ctrl #(.NBUF(NBUF), .TAG_W(TAG_W), .WB_EN(WB_EN)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_we(req_we), .req_tag(req_tag),
        .req_hit(hit), .hit_idx(hit_idx), .flush_req(flush_req),
        .lru_victim(lru_victim), .valid_vec(valid_vec), .dirty_vec(dirty_vec),
        .stall(stall), .nvm_rd_en(nvm_rd_en), .nvm_wr_en(nvm_wr_en),
        .flush_done(flush_done), .touch_en(touch_en), .touch_idx(touch_idx),
        .word_we(word_we), .fill_en(fill_en), .clean_en(clean_en),
        .sel_idx(sel_idx), .fill_tag(fill_tag)
    );

    AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        nvm_rd_en |=> (hit || !req_valid || ($past(req_tag) != req_tag))); // R6
endmodule

// File: tb/pbuf_mgr_tb.sv
module pbuf_mgr_tb_top;
    localparam int NB = 16, WD = 8, WW = 16, TW = 12, AW = TW + 3, PB = WD * WW;
    localparam int PNB = 8, PWW = 24, PPB = WD * PWW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int n_chk = 0, n_bad = 0;

    // data-side instance signals
    logic          req_valid = 0, req_we = 0, flush_req = 0;
    logic [AW-1:0] req_addr = '0;
    logic [WW-1:0] req_wdata = '0, rsp_rdata;
    logic          stall, flush_done, nvm_rd_en, nvm_wr_en;
    logic [TW-1:0] nvm_rd_page, nvm_wr_page;
    logic [PB-1:0] nvm_rd_data, nvm_wr_data;

    // program-side instance signals
    logic           p_valid = 0, p_we = 0, p_flush = 0;
    logic [AW-1:0]  p_addr = '0;
    logic [PWW-1:0] p_wdata = '0, p_rdata;
    logic           p_stall, p_done, p_rd_en, p_wr_en;
    logic [TW-1:0]  p_rd_page, p_wr_page;
    logic [PPB-1:0] p_rd_data, p_wr_data;

    pbuf_mgr dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .stall(stall), .flush_req(flush_req), .flush_done(flush_done),
        .nvm_rd_en(nvm_rd_en), .nvm_rd_page(nvm_rd_page), .nvm_rd_data(nvm_rd_data),
        .nvm_wr_en(nvm_wr_en), .nvm_wr_page(nvm_wr_page), .nvm_wr_data(nvm_wr_data)
    );

    pbuf_mgr #(.NBUF(PNB), .WW(PWW), .WB_EN(1'b0)) prog_i (
        .clk(clk), .rst_n(rst_n), .req_valid(p_valid), .req_we(p_we),
        .req_addr(p_addr), .req_wdata(p_wdata), .rsp_rdata(p_rdata),
        .stall(p_stall), .flush_req(p_flush), .flush_done(p_done),
        .nvm_rd_en(p_rd_en), .nvm_rd_page(p_rd_page), .nvm_rd_data(p_rd_data),
        .nvm_wr_en(p_wr_en), .nvm_wr_page(p_wr_page), .nvm_wr_data(p_wr_data)
    );

    // ---------------- main-memory model ----------------
    logic [PB-1:0] nvm_mem [int];
    int nvm_gen = 0;

    function automatic logic [PB-1:0] pat16(int t);
        logic [PB-1:0] p;
        for (int k = 0; k < WD; k++) p[k*WW +: WW] = 16'(t * 257 + k * 17 + 7);
        return p;
    endfunction

    function automatic logic [PPB-1:0] pat24(int t);
        logic [PPB-1:0] p;
        for (int k = 0; k < WD; k++) p[k*PWW +: PWW] = 24'(t * 66051 + k * 49 + 3);
        return p;
    endfunction

    function automatic logic [PB-1:0] nvm_get(int t);
        return nvm_mem.exists(t) ? nvm_mem[t] : pat16(t);
    endfunction

    always @(nvm_rd_page or nvm_gen) nvm_rd_data = nvm_get(int'(nvm_rd_page));
    always @(p_rd_page) p_rd_data = pat24(int'(p_rd_page));

    // ---------------- reference model ----------------
    logic [PB-1:0] m_page [NB];
    int m_tag [NB];
    bit m_val [NB], m_dirty [NB];
    int lruq [$];
    int ms = 0, mvic = 0, mptag = 0;
    bit last_stall = 0;

    task automatic chk(string req, logic [PPB-1:0] act, logic [PPB-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        lruq.delete();
        for (int i = 0; i < NB; i++) begin
            m_val[i] = 0; m_dirty[i] = 0; m_tag[i] = 0;
            lruq.push_back(i);
        end
        ms = 0;
    endtask

    function automatic int find_hit(int t);
        for (int i = 0; i < NB; i++) if (m_val[i] && m_tag[i] == t) return i;
        return -1;
    endfunction

    function automatic int first_dirty();
        for (int i = 0; i < NB; i++) if (m_dirty[i]) return i;
        return -1;
    endfunction

    task automatic touch(int b);
        foreach (lruq[j]) if (lruq[j] == b) begin lruq.delete(j); break; end
        lruq.push_front(b);
    endtask

    task automatic compare();
        int t, h, fd;
        bit e_stall, e_rd, e_wr, e_done;
        t = int'(req_addr[AW-1:3]);
        h = find_hit(t);
        fd = first_dirty();
        e_stall = 1; e_rd = 0; e_wr = 0; e_done = 0;
        case (ms)
            0: e_stall = req_valid && (flush_req || h < 0);
            1: e_wr = 1;
            2: e_rd = 1;
            default: begin e_wr = (fd >= 0); e_done = (fd < 0); end
        endcase
        chk("R3/R6 stall", stall, e_stall);
        chk("R3 rd_en", nvm_rd_en, e_rd);
        chk("R5/R7 wr_en", nvm_wr_en, e_wr);
        chk("R7 flush_done", flush_done, e_done);
        if (e_rd) chk("R3 rd_page", nvm_rd_page, mptag);
        if (e_wr && ms == 1) begin
            chk("R5 wr_page", nvm_wr_page, m_tag[mvic]);
            chk("R5 wr_data", nvm_wr_data, m_page[mvic]);
        end
        if (e_wr && ms == 3) begin
            chk("R7 wr_page", nvm_wr_page, m_tag[fd]);
            chk("R7 wr_data", nvm_wr_data, m_page[fd]);
        end
        if (ms == 0 && req_valid && !e_stall)
            chk("R1/R2 rdata", rsp_rdata, m_page[h][req_addr[2:0]*WW +: WW]);
        last_stall = e_stall;
    endtask

    task automatic advance();
        int t, h, fd;
        t = int'(req_addr[AW-1:3]);
        h = find_hit(t);
        fd = first_dirty();
        case (ms)
            0: begin
                if (flush_req) ms = 3;
                else if (req_valid && h >= 0) begin
                    touch(h);
                    if (req_we) begin
                        m_page[h][req_addr[2:0]*WW +: WW] = req_wdata;
                        m_dirty[h] = 1;
                    end
                end else if (req_valid) begin
                    mvic = lruq[$];
                    mptag = t;
                    ms = (m_val[mvic] && m_dirty[mvic]) ? 1 : 2;
                end
            end
            1: begin
                nvm_mem[m_tag[mvic]] = m_page[mvic];
                nvm_gen++;
                m_dirty[mvic] = 0;
                ms = 2;
            end
            2: begin
                m_page[mvic] = nvm_get(mptag);
                m_tag[mvic] = mptag;
                m_val[mvic] = 1;
                m_dirty[mvic] = 0;
                touch(mvic);
                ms = 0;
            end
            default: begin
                if (fd >= 0) begin
                    nvm_mem[m_tag[fd]] = m_page[fd];
                    nvm_gen++;
                    m_dirty[fd] = 0;
                end else ms = 0;
            end
        endcase
    endtask

    // inputs are set just after a falling edge; compare 1 ns later
    task automatic tick();
        #1;
        compare();
        advance();
        @(negedge clk);
    endtask

    task automatic access(bit we, int page, int off, logic [WW-1:0] d, bit fl);
        int guard = 0;
        req_valid = 1; req_we = we; req_addr = AW'(page * 8 + off);
        req_wdata = d; flush_req = fl;
        tick();
        flush_req = 0;
        while (last_stall && guard < 40) begin tick(); guard++; end
        req_valid = 0; req_we = 0;
    endtask

    task automatic flush();
        int guard = 0;
        flush_req = 1;
        tick();
        flush_req = 0;
        while (ms != 0 && guard < 40) begin tick(); guard++; end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R9: outputs quiet during reset
        chk("R9 stall", stall, 0);
        chk("R9 rd_en", nvm_rd_en, 0);
        chk("R9 wr_en", nvm_wr_en, 0);
        chk("R9 flush_done", flush_done, 0);
        rst_n = 1;
        repeat (3) tick();  // R9: idle after reset

        // R3/R6/R1: cold miss then hits
        access(0, 1, 2, '0, 0);
        access(0, 1, 5, '0, 0);
        // R2: write hit then read back
        access(1, 1, 5, 16'hBEEF, 0);
        access(0, 1, 5, '0, 0);
        // R4: fill all buffers, refresh page 1, overflow
        for (int p = 2; p <= 16; p++) access(0, p, p % 8, '0, 0);
        access(0, 1, 0, '0, 0);
        access(0, 17, 1, '0, 0);
        access(0, 1, 5, '0, 0);
        // R5: dirty evictions under mixed traffic
        for (int p = 18; p <= 45; p++)
            access(p % 3 == 0, p, p % 8, 16'(p * 1111), 0);
        for (int p = 2; p <= 12; p++) access(0, p, 3, '0, 0);
        access(0, 1, 5, '0, 0);   // round trip through write-back
        // R7: flush with dirty buffers
        for (int p = 40; p <= 44; p++) access(1, p, 1, 16'(p), 0);
        flush();
        // R10: flush and missing request together
        for (int p = 2; p <= 4; p++) access(1, p, 6, 16'(p + 9), 0);
        access(0, 60, 4, '0, 1);
        // R7: flush with nothing dirty
        flush();
        repeat (2) tick();

        // ---- program side (directed) ----
        @(negedge clk);
        p_valid = 1; p_addr = AW'(5 * 8 + 3);
        #1 chk("R3 prog miss stall", p_stall, 1);
        @(negedge clk);
        #1 chk("R3 prog rd_en", p_rd_en, 1);
        chk("R3 prog rd_page", p_rd_page, 5);
        @(negedge clk);
        #1 chk("R6 prog stall release", p_stall, 0);
        chk("R1 prog rdata", p_rdata, pat24(5)[3*PWW +: PWW]);
        @(negedge clk);
        p_we = 1; p_wdata = 24'h123456;
        #1 chk("R2 prog write hit", p_stall, 0);
        @(negedge clk);
        p_we = 0;
        #1 chk("R2 prog write ignored", p_rdata, pat24(5)[3*PWW +: PWW]);
        @(negedge clk);
        p_valid = 0; p_flush = 1;
        #1 chk("R8 prog no wr", p_wr_en, 0);
        @(negedge clk);
        p_flush = 0;
        #1 chk("R8 prog flush_done", p_done, 1);
        chk("R8 prog no wr at done", p_wr_en, 0);
        @(negedge clk);
        #1 chk("R8 prog done pulse", p_done, 0);
        finish_run();
    end
endmodule